// File: doc/BRIEF.md
# Gated Ternary-Pattern Decoder

This block is a purely combinational decoder with a gate input. A small group of input lines forms a binary code: bit i of `code_i` has weight 2^i, and the code is the sum of the weights of the lines that are high. The block drives a set of output lines. Each output has its own ternary pattern: every bit of the pattern is 0, 1 or don't-care. An output is active when the code agrees with its pattern in every bit that is not don't-care.

Patterns can overlap, so one code can activate several outputs at once. When the gate is at its disabling level, nothing is decoded and every output sits at its inactive level. The patterns are fixed at elaboration. Each output has an N-bit value vector and an N-bit care mask, and a care bit of 0 marks a don't-care position. Output k takes bits [k*N_IN +: N_IN] of `PAT_VAL` and `PAT_CARE`. Two parameters set whether the gate is active-high or active-low and whether the outputs are active-high or active-low.

The default configuration has 3 inputs and 8 outputs. The patterns for outputs 0 to 7 are, in order: 000, 001, 010, 011, 100, X01, 11X, 1X1.

Top module: `ternary_decoder`

## Requirements
- R1: Bit i of `code_i` carries weight 2^i. With defaults, raising only bit 0, only bit 1 or only bit 2 (gate enabled) selects code 1, 2 or 4 and activates output 1, 2 or 4 respectively.
- R2: An output whose care mask is all ones is active exactly when the code equals its value. With defaults, outputs 0 to 4 respond to codes 0 to 4 only, and at most one of them is active at a time.
- R3: A don't-care bit (care bit 0) has no effect on its output. With defaults, output 6 (11X) is active for codes 6 and 7, output 5 (X01) for codes 1 and 5, and output 7 (1X1) for codes 5 and 7.
- R4: Several outputs may be active together. With defaults and code 1, outputs 1 and 5 are both active and no others are.
- R5: When the gate is at its disabling level, every output is at its inactive level for all codes.
- R6: `GATE_ACT_HIGH`=1 makes `gate_i`=1 enable decoding. `GATE_ACT_HIGH`=0 makes `gate_i`=0 enable decoding.
- R7: `OUT_ACT_HIGH`=1 drives active outputs to 1 and inactive outputs to 0. `OUT_ACT_HIGH`=0 drives active outputs to 0 and inactive outputs to 1.
- R8: The outputs depend only on the present inputs. There is no clock or stored state, and a change on the inputs shows on `dec_o` without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_i | input | N_IN | Binary-weighted input lines; bit i has weight 2^i |
| gate_i | input | 1 | Decode enable; its polarity is set by GATE_ACT_HIGH |
| dec_o | output | N_OUT | Decoded outputs; bit k is the match for pattern k, at the level set by OUT_ACT_HIGH |

## Verification
The block holds no state, so any fault shows on `dec_o` during the same input settle. No clock edge is needed before it can be seen. Some faults act on the whole output vector: a wrongly masked pattern bit, a swapped bit weight, an inverted gate or an inverted output level. Each of these changes `dec_o` for at least one of the 16 combinations of code and gate. The bench walks every code with both gate levels, on an active-high instance and on an active-low instance. Each result is compared with values computed by arithmetic on the code, so a wrong bit shows within one step of the sweep.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;

  // True when every cared-for bit of code agrees with val.
  function automatic logic pat_hit(input logic [31:0] code,
                                   input logic [31:0] val,
                                   input logic [31:0] care);
    return ~|((code ^ val) & care);
  endfunction

endpackage

// File: rtl/dcd_gate_norm.sv
`timescale 1ns/1ps
module dcd_gate_norm #(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic gate_i,
  output logic en_o
);

  assign en_o = ACT_HIGH ? gate_i : ~gate_i;

endmodule

// File: rtl/dcd_match.sv
`timescale 1ns/1ps
module dcd_match #(
  parameter int                N_IN = 3,
  parameter logic [N_IN-1:0]   VAL  = '0,
  parameter logic [N_IN-1:0]   CARE = '1
) (
  input  logic [N_IN-1:0] code_i,
  input  logic            en_i,
  output logic            hit_o
);
  import dcd_pkg::*;

  localparam int PadW = 32 - N_IN;

  logic [31:0] code_w, val_w, care_w;

  assign code_w = {{PadW{1'b0}}, code_i};
  assign val_w  = {{PadW{1'b0}}, VAL};
  assign care_w = {{PadW{1'b0}}, CARE};
  assign hit_o  = en_i & pat_hit(code_w, val_w, care_w);

endmodule

// File: rtl/dcd_out_drv.sv
`timescale 1ns/1ps
module dcd_out_drv #(
  parameter int N_OUT    = 8,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic [N_OUT-1:0] hit_i,
  output logic [N_OUT-1:0] dec_o
);

  generate
    if (ACT_HIGH) begin : g_hi
      assign dec_o = hit_i;
    end else begin : g_lo
      assign dec_o = ~hit_i;
    end
  endgenerate

endmodule

// File: rtl/ternary_decoder.sv
`timescale 1ns/1ps
module ternary_decoder #(
  parameter int                      N_IN          = 3,
  parameter int                      N_OUT         = 8,
  parameter logic [N_OUT*N_IN-1:0]   PAT_VAL       = 24'b101_110_001_100_011_010_001_000,
  parameter logic [N_OUT*N_IN-1:0]   PAT_CARE      = 24'b101_110_011_111_111_111_111_111,
  parameter bit                      GATE_ACT_HIGH = 1'b1,
  parameter bit                      OUT_ACT_HIGH  = 1'b1
) (
  input  logic [N_IN-1:0]  code_i,
  input  logic             gate_i,
  output logic [N_OUT-1:0] dec_o
);

  logic             en;
  logic [N_OUT-1:0] hit;

  dcd_gate_norm #(.ACT_HIGH(GATE_ACT_HIGH)) u_gate (
    .gate_i (gate_i),
    .en_o   (en)
  );

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_pat
      dcd_match #(
        .N_IN (N_IN),
        .VAL  (PAT_VAL[k*N_IN +: N_IN]),
        .CARE (PAT_CARE[k*N_IN +: N_IN])
      ) u_match (
        .code_i (code_i),
        .en_i   (en),
        .hit_o  (hit[k])
      );
    end
  endgenerate

  dcd_out_drv #(.N_OUT(N_OUT), .ACT_HIGH(OUT_ACT_HIGH)) u_drv (
    .hit_i (hit),
    .dec_o (dec_o)
  );

endmodule

// File: rtl/ternary_decoder_chk.sv
`timescale 1ns/1ps
module ternary_decoder_chk #(
  parameter int                      N_IN          = 3,
  parameter int                      N_OUT         = 8,
  parameter logic [N_OUT*N_IN-1:0]   PAT_VAL       = '0,
  parameter logic [N_OUT*N_IN-1:0]   PAT_CARE      = '1,
  parameter bit                      GATE_ACT_HIGH = 1'b1,
  parameter bit                      OUT_ACT_HIGH  = 1'b1
) (
  input logic [N_IN-1:0]  code_i,
  input logic             gate_i,
  input logic [N_OUT-1:0] dec_o
);

  logic             en_c;
  logic [N_OUT-1:0] want, act, exact;

  always_comb begin
    en_c = (gate_i == GATE_ACT_HIGH);
    act  = OUT_ACT_HIGH ? dec_o : ~dec_o;
    for (int k = 0; k < N_OUT; k++) begin
      want[k]  = en_c;
      exact[k] = 1'b1;
      for (int b = 0; b < N_IN; b++) begin
        if (PAT_CARE[k*N_IN+b] && (code_i[b] != PAT_VAL[k*N_IN+b])) want[k] = 1'b0;
        if (!PAT_CARE[k*N_IN+b]) exact[k] = 1'b0;
      end
    end

    p_gate_off_r5: assert (en_c || act == '0)
      else $error("gate disabled but output active");
    p_pattern_r3: assert (act == want)
      else $error("output differs from ternary match");
    p_exact_onehot_r2: assert ($onehot0(act & exact))
      else $error("more than one exact-code output active");
    p_known_r8: assert (!$isunknown(dec_o))
      else $error("output unknown with known inputs");
  end

endmodule

bind ternary_decoder ternary_decoder_chk #(
  .N_IN          (N_IN),
  .N_OUT         (N_OUT),
  .PAT_VAL       (PAT_VAL),
  .PAT_CARE      (PAT_CARE),
  .GATE_ACT_HIGH (GATE_ACT_HIGH),
  .OUT_ACT_HIGH  (OUT_ACT_HIGH)
) u_chk (
  .code_i (code_i),
  .gate_i (gate_i),
  .dec_o  (dec_o)
);

// File: tb/sim_ternary_decoder.sv
`timescale 1ns/1ps
module sim_ternary_decoder;

  logic       clk    = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] code   = 3'd0;
  logic       gate   = 1'b0;
  logic       gate_n = 1'b1;
  logic [7:0] dec_hi, dec_lo;
  int         errors = 0;
  int         checks = 0;
  bit         done   = 1'b0;

  always #4 clk = ~clk;

  ternary_decoder u0 (
    .code_i (code),
    .gate_i (gate),
    .dec_o  (dec_hi)
  );

  ternary_decoder #(.GATE_ACT_HIGH(1'b0), .OUT_ACT_HIGH(1'b0)) u1 (
    .code_i (code),
    .gate_i (gate_n),
    .dec_o  (dec_lo)
  );

  // Expected active set, derived arithmetically from the pattern list.
  function automatic logic [7:0] model(input int c, input bit en);
    logic [7:0] r;
    r = '0;
    if (en) begin
      for (int k = 0; k < 5; k++) r[k] = (c == k);
      r[5] = (c % 4) == 1;
      r[6] = c >= 6;
      r[7] = (c == 5) || (c == 7);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: code=%0d gate=%0b got=%b exp=%b", req, code, gate, got, exp);
    end
  endtask

  task automatic apply(input int c, input bit en);
    @(posedge clk);
    code   = 3'(c);
    gate   = en;
    gate_n = ~en;
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset state u0", dec_hi, 8'h00);
    check("R5 reset state u1", dec_lo, 8'hFF);
    rst_ni = 1'b1;

    // R1: single weighted lines
    apply(1, 1'b1); check("R1 bit0 weight 1", dec_hi & 8'h1F, 8'h02);
    apply(2, 1'b1); check("R1 bit1 weight 2", dec_hi & 8'h1F, 8'h04);
    apply(4, 1'b1); check("R1 bit2 weight 4", dec_hi & 8'h1F, 8'h10);

    // R4: overlap of 001 and X01
    apply(1, 1'b1); check("R4 code1 multi-active", dec_hi, 8'b0010_0010);

    // R3: don't-care positions
    apply(6, 1'b1); check("R3 11X at code6", {7'd0, dec_hi[6]}, 8'd1);
    apply(7, 1'b1); check("R3 11X/1X1 at code7", dec_hi, 8'b1100_0000);
    apply(5, 1'b1); check("R3 X01/1X1 at code5", dec_hi, 8'b1010_0000);

    // R2/R5/R6/R7: full sweep on both polarities
    for (int g = 0; g < 2; g++) begin
      for (int c = 0; c < 8; c++) begin
        apply(c, g[0]);
        check(g ? "R2 sweep u0" : "R5 sweep gate off u0", dec_hi, model(c, g[0]));
        check(g ? "R6 sweep u1 active-low gate" : "R7 sweep u1 inactive high",
              dec_lo, ~model(c, g[0]));
      end
    end

    // R8: output follows input change mid-cycle, no edge in between
    apply(3, 1'b1);
    @(negedge clk);
    code = 3'd0;
    #1;
    check("R8 comb update u0", dec_hi, 8'b0000_0001);
    check("R8 comb update u1", dec_lo, 8'b1111_1110);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule